// File: doc/BRIEF.md
# Serial Port Interrupt Identification Unit

This block sits beside a serial port and decides which of its six interrupt sources the processor sees. The sources are: receive line status, network address match, receive buffer full, address transmitted, transmit buffer empty and modem status. Each source has a one-cycle event input that sets a sticky pending bit, and an enable input. The block returns a 4-bit identification value for the most urgent pending, enabled source, and drives one registered interrupt line.

Each pending bit is cleared by the register access that services it. The block receives strobes for five accesses: a read of receive data, a write of transmit data, a read of the identification value, a read of line status and a read of modem status. The identification value is frozen for as long as its read strobe is high, so the clear caused by that read cannot change the value being returned.

Top module: `sio_irq_ident`

## Requirements
- R1: After reset `id_o` is 4'b0001 and `irq_o` is 0, and no source is pending.
- R2: Bit 0 of `id_o` is 1 only when nothing is reported, and then bits 3:1 are 000. Otherwise bit 0 is 0 and bits 3:1 hold the source code: line status 011, network address 110, receive full 010, address transmitted 101, transmit empty 001, modem 000.
- R3: Among the enabled pending sources, the one reported is the first in this order: line status, network address, receive full, address transmitted, transmit empty, modem.
- R4: A disabled source is not reported, but its pending bit stays set and the source is reported once it is enabled. The network address source counts as enabled only when both `en_adr` and `en_rxf` are 1.
- R5: A line status read clears the line status source, and a modem status read clears the modem source. Neither access clears any other source.
- R6: A receive data read clears both the network address and receive full sources.
- R7: A transmit data write clears both the address transmitted and transmit empty sources. The first cycle of an identification read clears one of these two sources only when `id_o` is reporting that source at that cycle.
- R8: An event and a clearing access to the same source in the same cycle leave the source pending.
- R9: While `acc_rd_id` is high, `id_o` keeps the value it had when the read began. It follows the pending state again one cycle after the strobe drops.
- R10: `id_o` and `irq_o` are registered and show a new event two clock edges after it is sampled. When no identification read is in progress, `irq_o` is the inverse of `id_o[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_lsr | input | 1 | Line status event pulse |
| evt_adr | input | 1 | Network address match event pulse |
| evt_rxf | input | 1 | Receive buffer full event pulse |
| evt_atx | input | 1 | Address transmitted event pulse |
| evt_txe | input | 1 | Transmit buffer empty event pulse |
| evt_mdm | input | 1 | Modem status event pulse |
| en_lsr | input | 1 | Line status enable |
| en_adr | input | 1 | Network address enable |
| en_rxf | input | 1 | Receive full enable; also gates the network address source |
| en_atx | input | 1 | Address transmitted enable |
| en_txe | input | 1 | Transmit empty enable |
| en_mdm | input | 1 | Modem status enable |
| acc_rd_rx | input | 1 | Receive data read strobe |
| acc_wr_tx | input | 1 | Transmit data write strobe |
| acc_rd_id | input | 1 | Identification read strobe, held for the whole read |
| acc_rd_lsr | input | 1 | Line status read strobe |
| acc_rd_msr | input | 1 | Modem status read strobe |
| id_o | output | 4 | Identification value |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Two things can happen to one pending bit in the same cycle: a new event can set it while its servicing access clears it. The bench raises a receive-full event on the same edge as a receive data read. It expects the source to stay reported, and a later read alone must then clear it. The same kind of overlap occurs when an event arrives during an identification read. In that case the returned value must stay frozen, and the new source must appear only after the strobe drops.

// File: rtl/sio_irq_ident.sv
module sio_irq_ident (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_lsr,
  input  logic       evt_adr,
  input  logic       evt_rxf,
  input  logic       evt_atx,
  input  logic       evt_txe,
  input  logic       evt_mdm,
  input  logic       en_lsr,
  input  logic       en_adr,
  input  logic       en_rxf,
  input  logic       en_atx,
  input  logic       en_txe,
  input  logic       en_mdm,
  input  logic       acc_rd_rx,
  input  logic       acc_wr_tx,
  input  logic       acc_rd_id,
  input  logic       acc_rd_lsr,
  input  logic       acc_rd_msr,
  output logic [3:0] id_o,
  output logic       irq_o
);

  localparam logic [3:0] ID_NONE = 4'b0001;
  localparam logic [3:0] ID_LSR  = 4'b0110;
  localparam logic [3:0] ID_ADR  = 4'b1100;
  localparam logic [3:0] ID_RXF  = 4'b0100;
  localparam logic [3:0] ID_ATX  = 4'b1010;
  localparam logic [3:0] ID_TXE  = 4'b0010;
  localparam logic [3:0] ID_MDM  = 4'b0000;

  logic p_lsr, p_adr, p_rxf, p_atx, p_txe, p_mdm;
  logic rd_id_q;
  logic [3:0] id_next;

  wire rd_id_start = acc_rd_id & ~rd_id_q;
  wire clr_atx = acc_wr_tx | (rd_id_start & (id_o == ID_ATX));
  wire clr_txe = acc_wr_tx | (rd_id_start & (id_o == ID_TXE));

  wire a_lsr = p_lsr & en_lsr;
  wire a_adr = p_adr & en_adr & en_rxf;
  wire a_rxf = p_rxf & en_rxf;
  wire a_atx = p_atx & en_atx;
  wire a_txe = p_txe & en_txe;
  wire a_mdm = p_mdm & en_mdm;

  always_comb begin
    if (a_lsr)      id_next = ID_LSR;
    else if (a_adr) id_next = ID_ADR;
    else if (a_rxf) id_next = ID_RXF;
    else if (a_atx) id_next = ID_ATX;
    else if (a_txe) id_next = ID_TXE;
    else if (a_mdm) id_next = ID_MDM;
    else            id_next = ID_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_lsr <= 1'b0;
      p_adr <= 1'b0;
      p_rxf <= 1'b0;
      p_atx <= 1'b0;
      p_txe <= 1'b0;
      p_mdm <= 1'b0;
    end else begin
      p_lsr <= evt_lsr | (p_lsr & ~acc_rd_lsr);
      p_adr <= evt_adr | (p_adr & ~acc_rd_rx);
      p_rxf <= evt_rxf | (p_rxf & ~acc_rd_rx);
      p_atx <= evt_atx | (p_atx & ~clr_atx);
      p_txe <= evt_txe | (p_txe & ~clr_txe);
      p_mdm <= evt_mdm | (p_mdm & ~acc_rd_msr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_o    <= ID_NONE;
      irq_o   <= 1'b0;
      rd_id_q <= 1'b0;
    end else begin
      rd_id_q <= acc_rd_id;
      irq_o   <= ~id_next[0];
      if (!acc_rd_id) id_o <= id_next;
    end
  end

endmodule

// File: rtl/sio_irq_ident_chk.sv
module sio_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_lsr,
  input logic       evt_atx,
  input logic       evt_txe,
  input logic       evt_rxf,
  input logic       en_lsr,
  input logic       acc_rd_id,
  input logic       acc_rd_lsr,
  input logic       acc_wr_tx,
  input logic       p_lsr,
  input logic       p_atx,
  input logic       p_txe,
  input logic       p_rxf,
  input logic [3:0] id_o,
  input logic       irq_o
);

  assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    id_o[0] |-> id_o[3:1] == 3'b000);

  assert_lsr_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_lsr && en_lsr) ##1 (en_lsr && !acc_rd_id) |=> id_o == 4'b0110);

  assert_lsr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd_lsr && !evt_lsr) |=> !p_lsr);

  assert_tx_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr_tx && !evt_atx && !evt_txe) |=> (!p_atx && !p_txe));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rxf |=> p_rxf);

  assert_id_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_rd_id) |-> $stable(id_o));

  assert_irq_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!acc_rd_id) |-> irq_o == !id_o[0]);

endmodule

bind sio_irq_ident sio_irq_ident_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_lsr(evt_lsr), .evt_atx(evt_atx),
  .evt_txe(evt_txe), .evt_rxf(evt_rxf), .en_lsr(en_lsr),
  .acc_rd_id(acc_rd_id), .acc_rd_lsr(acc_rd_lsr), .acc_wr_tx(acc_wr_tx),
  .p_lsr(p_lsr), .p_atx(p_atx), .p_txe(p_txe), .p_rxf(p_rxf),
  .id_o(id_o), .irq_o(irq_o)
);

// File: tb/sio_irq_ident_bench.sv
`timescale 1ns/1ps
module sio_irq_ident_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] ev = '0;
  logic [5:0] en = '0;
  logic rd_rx = 0, wr_tx = 0, rd_id = 0, rd_lsr = 0, rd_msr = 0;
  logic [3:0] id_o;
  logic irq_o;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  sio_irq_ident u_sio_irq_ident (
    .clk(clk), .rst_n(rst_n),
    .evt_lsr(ev[0]), .evt_adr(ev[1]), .evt_rxf(ev[2]),
    .evt_atx(ev[3]), .evt_txe(ev[4]), .evt_mdm(ev[5]),
    .en_lsr(en[0]), .en_adr(en[1]), .en_rxf(en[2]),
    .en_atx(en[3]), .en_txe(en[4]), .en_mdm(en[5]),
    .acc_rd_rx(rd_rx), .acc_wr_tx(wr_tx), .acc_rd_id(rd_id),
    .acc_rd_lsr(rd_lsr), .acc_rd_msr(rd_msr),
    .id_o(id_o), .irq_o(irq_o)
  );

  function automatic logic [3:0] exp_id(input logic [5:0] p, input logic [5:0] e);
    if (p[0] & e[0])             return 4'b0110;
    else if (p[1] & e[1] & e[2]) return 4'b1100;
    else if (p[2] & e[2])        return 4'b0100;
    else if (p[3] & e[3])        return 4'b1010;
    else if (p[4] & e[4])        return 4'b0010;
    else if (p[5] & e[5])        return 4'b0000;
    else                         return 4'b0001;
  endfunction

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string r, input logic [3:0] want, input logic want_irq);
    total++;
    if (id_o !== want || irq_o !== want_irq) begin
      bad++;
      $display("FAIL %s: id=%b irq=%b expected id=%b irq=%b", r, id_o, irq_o, want, want_irq);
    end
  endtask

  task automatic do_reset;
    rst_n = 0; ev = '0; rd_rx = 0; wr_tx = 0; rd_id = 0; rd_lsr = 0; rd_msr = 0;
    tick; tick;
    rst_n = 1;
    tick;
  endtask

  task automatic pulse_ev(input logic [5:0] s);
    ev = s; tick; ev = '0; tick;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset;
    chk("R1 reset", 4'b0001, 1'b0);

    // R3 R2 R10: every pending subset, all enabled
    for (int s = 0; s < 64; s++) begin
      do_reset;
      en = 6'h3f;
      pulse_ev(s[5:0]);
      chk("R3 subset", exp_id(s[5:0], 6'h3f), s != 0);
    end

    // R4: every enable mask with all sources pending
    do_reset;
    en = '0;
    pulse_ev(6'h3f);
    for (int e = 0; e < 64; e++) begin
      en = e[5:0];
      tick;
      chk("R4 mask", exp_id(6'h3f, e[5:0]), exp_id(6'h3f, e[5:0]) != 4'b0001);
    end

    // R5 R6 R7: clearing chain
    do_reset; en = 6'h3f; pulse_ev(6'h3f);
    chk("R3 all", 4'b0110, 1'b1);
    rd_lsr = 1; tick; rd_lsr = 0; tick;
    chk("R5 lsr read", 4'b1100, 1'b1);
    rd_rx = 1; tick; rd_rx = 0; tick;
    chk("R6 rx read", 4'b1010, 1'b1);
    rd_id = 1; tick; rd_id = 0; tick;
    chk("R7 id read clears atx", 4'b0010, 1'b1);
    rd_id = 1; tick; rd_id = 0; tick;
    chk("R7 id read clears txe", 4'b0000, 1'b1);
    rd_id = 1; tick; rd_id = 0; tick;
    chk("R5 id read keeps modem", 4'b0000, 1'b1);
    rd_msr = 1; tick; rd_msr = 0; tick;
    chk("R5 modem read", 4'b0001, 1'b0);

    // R7: id read while another source reported leaves txe
    do_reset; en = 6'h3f; pulse_ev(6'b010001);
    rd_id = 1; tick; rd_id = 0; tick;
    rd_lsr = 1; tick; rd_lsr = 0; tick;
    chk("R7 txe kept", 4'b0010, 1'b1);

    // R7: transmit write clears both
    do_reset; en = 6'h3f; pulse_ev(6'b111000);
    wr_tx = 1; tick; wr_tx = 0; tick;
    chk("R7 tx write", 4'b0000, 1'b1);

    // R8: set and clear collide
    do_reset; en = 6'h3f; pulse_ev(6'b000100);
    ev = 6'b000100; rd_rx = 1; tick; ev = '0; rd_rx = 0; tick;
    chk("R8 collision", 4'b0100, 1'b1);
    rd_rx = 1; tick; rd_rx = 0; tick;
    chk("R6 rx cleared", 4'b0001, 1'b0);

    // R9: value frozen during a read
    do_reset; en = 6'h3f; pulse_ev(6'b010000);
    rd_id = 1; tick;
    chk("R9 read start", 4'b0010, 1'b1);
    ev = 6'b000001; tick; ev = '0; tick;
    chk("R9 held", 4'b0010, 1'b1);
    rd_id = 0; tick;
    chk("R9 released", 4'b0110, 1'b1);

    // R10: two-edge latency
    do_reset; en = 6'h3f;
    ev = 6'b100000; tick; ev = '0;
    chk("R10 not yet", 4'b0001, 1'b0);
    tick;
    chk("R10 visible", 4'b0000, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule